// File: doc/BRIEF.md
# Plug-and-Play Initiation Key Detector

This block sits behind the byte-wide address port of a plug-and-play card and watches every byte written to it. While the card waits for its key, each written byte is compared with the next byte of a 32-byte initiation key. The expected byte comes from an 8-bit linear feedback shift register stepped once per matching byte, so no key table is stored. A write of 0x00, which host software sends twice before the key, restarts the comparison. A wrong byte also restarts it.

Once all 32 bytes have matched, the card is in configuration mode. An address-port write then selects a register index, and a write-data port write loads that register. Index 6 holds the card number, index 7 the logical device and index 0x30 its activate bit. A write with bit 1 set to index 2 sends the card back to waiting for the key. Selecting index 1 starts serial isolation. The card's 72-bit identifier is then returned one bit per pair of reads on the read-data port, as 0x55/0xAA for a one and 0x00/0x00 for a zero.

Top module: `pnp_init_key`

## Requirements
- R1: After reset `key_ok` is 0, `card_num`, `dev_sel` and `dev_active` are 0, and `rd_data` is 0x00.
- R2: The key is 32 bytes. The first byte is 0x6A. Each following byte equals the previous byte shifted right by one, with bit 7 set to bit 0 XOR bit 1 of the previous byte. `key_ok` is 1 in the cycle after the 32nd matching address-port write, and not after only 31.
- R3: While waiting for the key, an address-port write of 0x00 restarts the match, so the next expected byte is 0x6A.
- R4: While waiting for the key, any other byte that does not match restarts the match. If that byte is 0x6A, it counts as the first key byte.
- R5: While `key_ok` is 0, write-data port writes do not change `card_num`, `dev_sel` or `dev_active`.
- R6: In configuration mode, an address-port write sets the register index. A write-data port write then loads `card_num` at index 6, loads `dev_sel` at index 7, or sets `dev_active` to bit 0 of the byte at index 0x30.
- R7: With index 1 selected in configuration mode, identifier bit k is `card_id[k]`, so byte n is `card_id[8n+7:8n]`, least significant bit first. Before the first read of a pair, `rd_data` is 0x55 for a one and 0x00 for a zero. Before the second read, it is 0xAA for a one and 0x00 for a zero. Each `rd_stb` advances one read. Writing index 1 again restarts at bit 0.
- R8: After all 72 bits have been read, `rd_data` stays 0x00 and further reads have no effect.
- R9: In configuration mode, a write-data port write to index 2 with bit 1 set clears `key_ok`. The full key must then be sent again.
- R10: `rd_data` is 0x00 whenever the card is not in configuration mode or the index is not 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_wr | input | 1 | Write strobe for the address port |
| data_wr | input | 1 | Write strobe for the write-data port |
| wr_byte | input | 8 | Byte written on either port |
| rd_stb | input | 1 | Read strobe for the read-data port |
| card_id | input | 72 | Card identifier, bit 0 sent first |
| key_ok | output | 1 | Card is in configuration mode |
| rd_data | output | 8 | Read-data port value |
| card_num | output | 8 | Assigned card number |
| dev_sel | output | 8 | Selected logical device |
| dev_active | output | 1 | Activate bit of the logical device |

## Verification
On every cycle, the assertions check the following:
- the match counter stays below the key length;
- a zero write restarts the match;
- configuration mode holds until it is left;
- configuration registers stay frozen while waiting for the key;
- the read-data port only ever shows 0x00, 0x55 or 0xAA;
- the isolation bit counter saturates.

Only the bench's scenarios can show the rest. It checks that the LFSR sequence really is the key. It sends a wrong byte at every one of the 32 positions and shows that matching restarts. It walks both read phases of all 72 identifier bits for two identifiers, so the bit order is exercised.

// File: rtl/pnp_key_pkg.sv
package pnp_key_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] IDX_ISO  = 8'h01;
  localparam logic [BYTE_W-1:0] IDX_CTRL = 8'h02;
  localparam logic [BYTE_W-1:0] IDX_CSN  = 8'h06;
  localparam logic [BYTE_W-1:0] IDX_LDN  = 8'h07;
  localparam logic [BYTE_W-1:0] IDX_ACT  = 8'h30;
  localparam logic [BYTE_W-1:0] RD_ONE_A = 8'h55;
  localparam logic [BYTE_W-1:0] RD_ONE_B = 8'hAA;

  // one step of the key generator: shift right, feedback into bit 7
  function automatic logic [BYTE_W-1:0] key_step(input logic [BYTE_W-1:0] b);
    return {b[0] ^ b[1], b[BYTE_W-1:1]};
  endfunction
endpackage

// File: rtl/pnp_key_match.sv
module pnp_key_match
  import pnp_key_pkg::*;
#(
  parameter int KEY_LEN = 32,
  parameter logic [BYTE_W-1:0] SEED = 8'h6A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_wr,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              leave,
  output logic              key_ok
);
  localparam int CW = $clog2(KEY_LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(KEY_LEN - 1);

  logic [BYTE_W-1:0] exp_q, exp_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              ok_q, ok_d;

  always_comb begin
    exp_d = exp_q;
    cnt_d = cnt_q;
    ok_d  = ok_q;
    if (ok_q) begin
      if (leave) begin
        ok_d  = 1'b0;
        exp_d = SEED;
        cnt_d = '0;
      end
    end else if (byte_wr) begin
      if (byte_val == exp_q) begin
        if (cnt_q == LAST) begin
          ok_d  = 1'b1;
          exp_d = SEED;
          cnt_d = '0;
        end else begin
          exp_d = key_step(exp_q);
          cnt_d = cnt_q + 1'b1;
        end
      end else if (byte_val == SEED) begin
        exp_d = key_step(SEED);
        cnt_d = CW'(1);
      end else begin
        exp_d = SEED;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= SEED;
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else begin
      exp_q <= exp_d;
      cnt_q <= cnt_d;
      ok_q  <= ok_d;
    end
  end

  assign key_ok = ok_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(KEY_LEN));
  p_zero_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok_q && byte_wr && byte_val == '0) |=> (cnt_q == '0 && exp_q == SEED));
  p_key_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && !leave) |=> ok_q);
  p_key_leave_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_q && leave) |=> !ok_q);
endmodule

// File: rtl/pnp_cfg_regs.sv
module pnp_cfg_regs
  import pnp_key_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_ok,
  input  logic              addr_wr,
  input  logic              data_wr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              iso_sel,
  output logic              iso_restart,
  output logic              leave,
  output logic [BYTE_W-1:0] card_num,
  output logic [BYTE_W-1:0] dev_sel,
  output logic              dev_active
);
  logic [BYTE_W-1:0] idx_q, idx_d;
  logic [BYTE_W-1:0] csn_q, csn_d;
  logic [BYTE_W-1:0] ldn_q, ldn_d;
  logic              act_q, act_d;
  logic              cfg_wr;

  assign cfg_wr      = key_ok && data_wr;
  assign leave       = cfg_wr && (idx_q == IDX_CTRL) && wr_byte[1];
  assign iso_restart = key_ok && addr_wr && (wr_byte == IDX_ISO);
  assign iso_sel     = key_ok && (idx_q == IDX_ISO);

  always_comb begin
    idx_d = idx_q;
    csn_d = csn_q;
    ldn_d = ldn_q;
    act_d = act_q;
    if (key_ok && addr_wr) idx_d = wr_byte;
    if (cfg_wr) begin
      unique case (idx_q)
        IDX_CSN: csn_d = wr_byte;
        IDX_LDN: ldn_d = wr_byte;
        IDX_ACT: act_d = wr_byte[0];
        default: ;
      endcase
    end
    if (leave) idx_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      csn_q <= '0;
      ldn_q <= '0;
      act_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      csn_q <= csn_d;
      ldn_q <= ldn_d;
      act_q <= act_d;
    end
  end

  assign card_num   = csn_q;
  assign dev_sel    = ldn_q;
  assign dev_active = act_q;

  p_wfk_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ok |=> ($stable(csn_q) && $stable(ldn_q) && $stable(act_q)));
  p_act_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && idx_q == IDX_ACT) |=> (act_q == $past(wr_byte[0])));
  p_csn_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && idx_q == IDX_CSN) |=> (csn_q == $past(wr_byte)));
endmodule

// File: rtl/pnp_isolate.sv
module pnp_isolate
  import pnp_key_pkg::*;
#(
  parameter int ID_BITS = 72
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               restart,
  input  logic               rd_stb,
  input  logic [ID_BITS-1:0] card_id,
  output logic [BYTE_W-1:0]  rd_data
);
  localparam int BW = $clog2(ID_BITS + 1);
  localparam logic [BW-1:0] DONE = BW'(ID_BITS);

  logic [BW-1:0] bit_q, bit_d;
  logic          half_q, half_d;
  logic          cur_bit;
  logic          advance;

  assign advance = enable && rd_stb && (bit_q != DONE);
  assign cur_bit = (bit_q != DONE) ? card_id[bit_q] : 1'b0;

  always_comb begin
    bit_d  = bit_q;
    half_d = half_q;
    if (restart) begin
      bit_d  = '0;
      half_d = 1'b0;
    end else if (advance) begin
      if (half_q) begin
        half_d = 1'b0;
        bit_d  = bit_q + 1'b1;
      end else begin
        half_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      half_q <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      half_q <= half_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (enable && cur_bit) rd_data = half_q ? RD_ONE_B : RD_ONE_A;
  end

  p_rd_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data == 8'h00 || rd_data == RD_ONE_A || rd_data == RD_ONE_B));
  p_half_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !restart && !half_q) |=> half_q);
  p_bit_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= DONE);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_q == DONE && !restart) |=> (bit_q == DONE));
endmodule

// File: rtl/pnp_init_key.sv
module pnp_init_key
  import pnp_key_pkg::*;
#(
  parameter int KEY_LEN = 32,
  parameter int ID_BITS = 72,
  parameter logic [7:0] SEED = 8'h6A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               addr_wr,
  input  logic               data_wr,
  input  logic [7:0]         wr_byte,
  input  logic               rd_stb,
  input  logic [ID_BITS-1:0] card_id,
  output logic               key_ok,
  output logic [7:0]         rd_data,
  output logic [7:0]         card_num,
  output logic [7:0]         dev_sel,
  output logic               dev_active
);
  logic leave;
  logic iso_sel;
  logic iso_restart;

  pnp_key_match #(.KEY_LEN(KEY_LEN), .SEED(SEED)) u_match (
    .clk(clk), .rst_n(rst_n), .byte_wr(addr_wr), .byte_val(wr_byte),
    .leave(leave), .key_ok(key_ok)
  );

  pnp_cfg_regs u_cfg (
    .clk(clk), .rst_n(rst_n), .key_ok(key_ok), .addr_wr(addr_wr),
    .data_wr(data_wr), .wr_byte(wr_byte), .iso_sel(iso_sel),
    .iso_restart(iso_restart), .leave(leave), .card_num(card_num),
    .dev_sel(dev_sel), .dev_active(dev_active)
  );

  pnp_isolate #(.ID_BITS(ID_BITS)) u_iso (
    .clk(clk), .rst_n(rst_n), .enable(iso_sel), .restart(iso_restart),
    .rd_stb(rd_stb), .card_id(card_id), .rd_data(rd_data)
  );

  p_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !key_ok |-> (rd_data == 8'h00));
endmodule

// File: tb/pnp_init_key_test.sv
module pnp_init_key_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        addr_wr = 1'b0;
  logic        data_wr = 1'b0;
  logic [7:0]  wr_byte = 8'h00;
  logic        rd_stb = 1'b0;
  logic [71:0] card_id = '0;
  logic        key_ok;
  logic [7:0]  rd_data;
  logic [7:0]  card_num;
  logic [7:0]  dev_sel;
  logic        dev_active;
  int tests = 0;
  int fails = 0;
  logic [7:0] key [32];

  always #10 clk = ~clk;

  pnp_init_key uut (
    .clk(clk), .rst_n(rst_n), .addr_wr(addr_wr), .data_wr(data_wr),
    .wr_byte(wr_byte), .rd_stb(rd_stb), .card_id(card_id), .key_ok(key_ok),
    .rd_data(rd_data), .card_num(card_num), .dev_sel(dev_sel),
    .dev_active(dev_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wa(input logic [7:0] b);
    @(negedge clk); addr_wr = 1'b1; wr_byte = b;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic wd(input logic [7:0] b);
    @(negedge clk); data_wr = 1'b1; wr_byte = b;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  task automatic send_key(input int n);
    wa(8'h00); wa(8'h00);
    for (int i = 0; i < n; i++) wa(key[i]);
  endtask

  task automatic leave_cfg();
    wa(8'h02); wd(8'h02);
  endtask

  task automatic iso_sweep(input logic [71:0] id);
    card_id = id;
    wa(8'h01);
    for (int k = 0; k < 72; k++) begin
      chk("R7 first read", rd_data, id[k] ? 8'h55 : 8'h00);
      rd();
      chk("R7 second read", rd_data, id[k] ? 8'hAA : 8'h00);
      rd();
    end
    chk("R8 done", rd_data, 8'h00);
    rd(); rd();
    chk("R8 done after extra reads", rd_data, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    key[0] = 8'h6A;
    for (int i = 1; i < 32; i++)
      key[i] = (key[i-1] >> 1) | (8'((key[i-1][0] ^ key[i-1][1])) << 7);
    chk("R2 key byte 1", key[1], 8'hB5);
    chk("R2 key byte 7", key[7], 8'hBE);
    chk("R2 key byte 31", key[31], 8'h39);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 key_ok", key_ok, 0);
    chk("R1 card_num", card_num, 0);
    chk("R1 dev_sel", dev_sel, 0);
    chk("R1 dev_active", dev_active, 0);
    chk("R1 rd_data", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R5: data writes ignored while waiting
    wa(8'h06); wd(8'h5C);
    chk("R5 card_num frozen", card_num, 0);
    wa(8'h30); wd(8'h01);
    chk("R5 dev_active frozen", dev_active, 0);
    // R2: 31 bytes not enough, 32nd completes
    send_key(31);
    chk("R2 31 bytes", key_ok, 0);
    wa(key[31]);
    chk("R2 32 bytes", key_ok, 1);
    // R6 configuration registers
    wa(8'h06); wd(8'h02);
    chk("R6 card_num", card_num, 2);
    wa(8'h07); wd(8'h05);
    chk("R6 dev_sel", dev_sel, 5);
    wa(8'h30); wd(8'h01);
    chk("R6 dev_active set", dev_active, 1);
    chk("R10 index not 1", rd_data, 0);
    wd(8'h00);
    chk("R6 dev_active clear", dev_active, 0);
    // R7/R8 isolation sweeps
    iso_sweep(72'hA5_0123456789ABCDEF);
    iso_sweep(72'h3C_FEDCBA9876543210);
    // R7 restart mid-way
    card_id = 72'h00_0000000000000002;
    wa(8'h01); rd(); rd();
    chk("R7 bit1 first", rd_data, 8'h55);
    wa(8'h01);
    chk("R7 restart bit0", rd_data, 8'h00);
    // R9 leave
    leave_cfg();
    chk("R9 key_ok cleared", key_ok, 0);
    card_id = '1;
    chk("R10 not configured", rd_data, 0);
    wa(8'h06); wd(8'h77);
    chk("R9 writes ignored after leave", card_num, 2);
    // R4 sweep of wrong byte at each position
    for (int p = 0; p < 32; p++) begin
      logic [7:0] bad;
      bad = key[p] ^ 8'h01;
      if (bad == 8'h6A || bad == 8'h00) bad = key[p] ^ 8'h02;
      send_key(p);
      wa(bad);
      for (int i = p + 1; i < 32; i++) wa(key[i]);
      chk("R4 wrong byte restarts", key_ok, 0);
    end
    // R4: mismatched 0x6A starts a new match
    send_key(5);
    for (int i = 0; i < 32; i++) wa(key[i]);
    chk("R4 0x6A restarts as first", key_ok, 1);
    leave_cfg();
    // R3: zero write mid-key restarts
    send_key(10);
    wa(8'h00);
    for (int i = 10; i < 32; i++) wa(key[i]);
    chk("R3 zero restarts", key_ok, 0);
    wa(8'h00);
    for (int i = 0; i < 32; i++) wa(key[i]);
    chk("R3 full key after zero", key_ok, 1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule